// File: doc/BRIEF.md
# DMA Command Queue Register Front-End

This block is the host-visible register file for the control side of a DMA engine. It holds the command queue base address and end address. It also holds the producer (write) and consumer (read) pointers, an interrupt enable word and an interrupt status word. It drives one level-sensitive interrupt line. Software reaches it over a simple single-cycle register bus with a byte address, a write strobe, 32-bit write data and registered read data. The block moves no data itself.

An arming feature completes a queue update without a real engine behind it. Software writes a key value to the read-pointer slot, and the block arms. The next write-pointer update then flags both transfer directions as complete, and it raises the interrupt if either completion is enabled. Every write-pointer update copies the new value into the read pointer, so the queue always looks drained.

Top module: `cmdq_reg_frontend`

## Requirements
- R1: After reset, every register reads 0 except status (byte offset 0x24), which reads 0xF8000000. The interrupt is low and the arm flag is clear, so a following write-pointer write leaves status at 0xF8000000.
- R2: Plain slots store all 32 written bits, and a read returns the value on the cycle after the address is presented. The plain slots are the queue base (0x10) and every in-range offset without a special meaning (0x00–0x0C and 0x28–0x3C).
- R3: Writes to queue end (0x14) and write pointer (0x18) store only bits 17:0 (mask 0x0003FFFF), and the upper bits read as 0.
- R4: A write to the write pointer also loads the same masked value into the read pointer (0x1C).
- R5: A write of 0xEE882266 to offset 0x1C arms the block. No write to 0x1C ever changes the stored read pointer.
- R6: A write-pointer write while armed sets status bits 4 and 5 and disarms the block. A later write-pointer write without re-arming sets neither bit.
- R7: On that armed write-pointer write, the interrupt goes high if control bit 4 or bit 5 is 1. If both bits are 0, the interrupt stays low.
- R8: A write to interrupt control (0x20) stores the written value ANDed with 0xBFEFF07F.
- R9: A status write with bit 4 or bit 5 set clears both bits 4 and 5, keeps every other status bit, and drives the interrupt low. A status write with neither bit set changes nothing.
- R10: Byte offsets from 0x40 upward (word index ≥ NUM_REGS) read as 0, and writes to them alter no register.
- R11: The interrupt changes only on the arm-fire raise of R7, the clear of R9, or reset. Enabling control bits while status bits are already set does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (12) | Byte address; bits 1:0 ignored |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for last cycle's address |
| irq_o | output | 1 | Level interrupt |

## Verification
The checks assume that the bus presents at most one access per cycle and holds addr_i and wdata_i steady around the sampling edge. They also assume that we_i is a single-cycle strobe per write. The bench drives all inputs on the falling edge and pulses we_i for exactly one cycle. It parks the address at a plain slot between accesses and does not overlap a reset release with a write. As a result, every armed/fire and clear event that the properties observe comes from one clean write.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int DATA_W = 32;

  // word indices (byte offset / 4)
  localparam int IDX_END  = 5;
  localparam int IDX_WP   = 6;
  localparam int IDX_RP   = 7;
  localparam int IDX_CTRL = 8;
  localparam int IDX_STAT = 9;

  localparam logic [DATA_W-1:0] PTR_MASK  = 32'h0003_FFFF;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'hBFEF_F07F;
  localparam logic [DATA_W-1:0] ARM_KEY   = 32'hEE88_2266;
  localparam logic [DATA_W-1:0] STAT_RST  = 32'hF800_0000;
  localparam logic [DATA_W-1:0] CMPL_BITS = 32'h0000_0030;

  typedef enum logic [2:0] {
    K_PLAIN, K_END, K_WP, K_RP, K_CTRL, K_STAT, K_NONE
  } slot_kind_e;
endpackage

// File: rtl/cmdq_addr_dec.sv
module cmdq_addr_dec
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 16,
  localparam int WIDX_W  = ADDR_W - 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output slot_kind_e        kind_o
);
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_REGS);

  logic [WIDX_W-1:0] word;
  assign word  = addr_i[ADDR_W-1:2];
  assign idx_o = word[IDX_W-1:0];

  always_comb begin
    if (word >= LIMIT)                    kind_o = K_NONE;
    else if (word == WIDX_W'(IDX_END))    kind_o = K_END;
    else if (word == WIDX_W'(IDX_WP))     kind_o = K_WP;
    else if (word == WIDX_W'(IDX_RP))     kind_o = K_RP;
    else if (word == WIDX_W'(IDX_CTRL))   kind_o = K_CTRL;
    else if (word == WIDX_W'(IDX_STAT))   kind_o = K_STAT;
    else                                  kind_o = K_PLAIN;
  end
endmodule

// File: rtl/cmdq_arm_ctl.sv
module cmdq_arm_ctl
  import cmdq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_rp_i,
  input  logic              wr_wp_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o,
  output logic              fire_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            armed_q <= 1'b0;
    else if (wr_rp_i && wdata_i == ARM_KEY) armed_q <= 1'b1;
    else if (wr_wp_i && armed_q)            armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
  assign fire_o  = wr_wp_i && armed_q;
endmodule

// File: rtl/cmdq_irq_ctl.sv
module cmdq_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic en_i,
  input  logic clear_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              irq_q <= 1'b0;
    else if (fire_i && en_i)  irq_q <= 1'b1;
    else if (clear_i)         irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmdq_reg_frontend.sv
module cmdq_reg_frontend
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd;
  logic [NUM_REGS-1:0]             reg_we;
  logic [IDX_W-1:0]                idx;
  slot_kind_e                      kind;
  logic                            armed, fire, stat_clr, irq_en;
  logic [DATA_W-1:0]               rdata_q;
  logic [DATA_W-1:0]               ctrl_q, stat_q, end_q;

  cmdq_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i (addr_i),
    .idx_o  (idx),
    .kind_o (kind)
  );

  cmdq_arm_ctl u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_rp_i (we_i && kind == K_RP),
    .wr_wp_i (we_i && kind == K_WP),
    .wdata_i (wdata_i),
    .armed_o (armed),
    .fire_o  (fire)
  );

  assign ctrl_q   = regs_q[IDX_CTRL];
  assign stat_q   = regs_q[IDX_STAT];
  assign end_q    = regs_q[IDX_END];
  assign irq_en   = |(ctrl_q & CMPL_BITS);
  assign stat_clr = we_i && kind == K_STAT && |(wdata_i & CMPL_BITS);

  cmdq_irq_ctl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .en_i    (irq_en),
    .clear_i (stat_clr),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_we = '0;
    reg_wd = regs_q;
    if (we_i) begin
      unique case (kind)
        K_PLAIN: begin
          reg_we[idx] = 1'b1;
          reg_wd[idx] = wdata_i;
        end
        K_END: begin
          reg_we[IDX_END] = 1'b1;
          reg_wd[IDX_END] = wdata_i & PTR_MASK;
        end
        K_WP: begin
          reg_we[IDX_WP] = 1'b1;
          reg_wd[IDX_WP] = wdata_i & PTR_MASK;
          reg_we[IDX_RP] = 1'b1;
          reg_wd[IDX_RP] = wdata_i & PTR_MASK;
        end
        K_CTRL: begin
          reg_we[IDX_CTRL] = 1'b1;
          reg_wd[IDX_CTRL] = wdata_i & CTRL_MASK;
        end
        K_STAT: begin
          if (stat_clr) begin
            reg_we[IDX_STAT] = 1'b1;
            reg_wd[IDX_STAT] = stat_q & ~CMPL_BITS;
          end
        end
        default: ;  // K_RP arms only, K_NONE dropped
      endcase
    end
    if (fire) begin
      reg_we[IDX_STAT] = 1'b1;
      reg_wd[IDX_STAT] = stat_q | CMPL_BITS;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (g == IDX_STAT) ? STAT_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[g] <= RST_VAL;
      else if (reg_we[g]) regs_q[g] <= reg_wd[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (kind == K_NONE) ? '0 : regs_q[idx];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cmdq_reg_frontend_chk.sv
module cmdq_reg_frontend_chk
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              armed_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] end_q
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_REGS);

  logic [WIDX_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  // R5
  arm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && word == WIDX_W'(IDX_RP) && wdata_i == ARM_KEY) |=> armed_q);

  // R6
  fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && word == WIDX_W'(IDX_WP) && armed_q) |=> (!armed_q && stat_q[5:4] == 2'b11));

  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(we_i && word == WIDX_W'(IDX_WP) && armed_q && ctrl_q[5:4] != 2'b00));

  // R9
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(we_i && word == WIDX_W'(IDX_STAT) && wdata_i[5:4] != 2'b00));

  // R3
  end_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && word == WIDX_W'(IDX_END)) |=> end_q == ($past(wdata_i) & PTR_MASK));

  // R10
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word >= LIMIT) |=> rdata_o == '0);
endmodule

bind cmdq_reg_frontend cmdq_reg_frontend_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .armed_q (armed),
  .ctrl_q  (ctrl_q),
  .stat_q  (stat_q),
  .end_q   (end_q)
);

// File: tb/cmdq_reg_frontend_tb.sv
`timescale 1ns/1ps
module cmdq_reg_frontend_tb;
  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;  // write data or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h010, 32'hDEADBEEF, 4'd2},  // R2 base slot
    '{1'b0, 12'h010, 32'hDEADBEEF, 4'd2},
    '{1'b1, 12'h000, 32'h12345678, 4'd2},  // R2 spare slot
    '{1'b0, 12'h000, 32'h12345678, 4'd2},
    '{1'b1, 12'h03C, 32'hA5A5A5A5, 4'd2},
    '{1'b0, 12'h03C, 32'hA5A5A5A5, 4'd2},
    '{1'b1, 12'h014, 32'hFFFFFFFF, 4'd3},  // R3 end mask
    '{1'b0, 12'h014, 32'h0003FFFF, 4'd3},
    '{1'b1, 12'h018, 32'hABCDEF12, 4'd3},  // R3 wp mask
    '{1'b0, 12'h018, 32'h0001EF12, 4'd3},
    '{1'b0, 12'h01C, 32'h0001EF12, 4'd4},  // R4 rp mirror
    '{1'b1, 12'h01C, 32'h12345678, 4'd5},  // R5 non-key write
    '{1'b0, 12'h01C, 32'h0001EF12, 4'd5},
    '{1'b1, 12'h020, 32'hFFFFFFFF, 4'd8},  // R8 ctrl mask
    '{1'b0, 12'h020, 32'hBFEFF07F, 4'd8},
    '{1'b1, 12'h040, 32'h11111111, 4'd10}, // R10 out of range
    '{1'b0, 12'h040, 32'h00000000, 4'd10},
    '{1'b0, 12'hFFC, 32'h00000000, 4'd10},
    '{1'b0, 12'h000, 32'h12345678, 4'd10}, // R10 no alias onto slot 0
    '{1'b1, 12'h024, 32'h0F000000, 4'd9},  // R9 no-op status write
    '{1'b0, 12'h024, 32'hF8000000, 4'd9}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cmdq_reg_frontend u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 12'h000;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    @(posedge clk_i);
    #1 d = rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk_i);
    #1 chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset values
    for (int i = 0; i < 16; i++) begin
      rd(12'(i * 4), r);
      chk($sformatf("R1 reset slot %0d", i), r, (i == 9) ? 32'hF8000000 : 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, r);
        chk($sformatf("R%0d vec %0d", VEC[i].req, i), r, VEC[i].data);
      end
    end

    // R5 arm, rp not touched; ctrl has bits 4/5 enabled
    wr(12'h01C, 32'hEE882266);
    rd(12'h01C, r); chk("R5 key not stored", r, 32'h0001EF12);
    chk("R7 irq low before fire", {31'b0, irq_o}, 32'h0);
    wr(12'h018, 32'h00000100);
    chk("R7 irq raised", {31'b0, irq_o}, 32'h1);
    rd(12'h024, r); chk("R6 status set", r, 32'hF8000030);
    rd(12'h01C, r); chk("R4 rp copy", r, 32'h00000100);
    wr(12'h024, 32'h00000010);
    chk("R9 irq cleared", {31'b0, irq_o}, 32'h0);
    rd(12'h024, r); chk("R9 both cleared", r, 32'hF8000000);
    wr(12'h018, 32'h00000300);
    rd(12'h024, r); chk("R6 disarmed", r, 32'hF8000000);
    chk("R6 no irq", {31'b0, irq_o}, 32'h0);

    // R7 disabled: status set, no irq
    wr(12'h020, 32'h0);
    wr(12'h01C, 32'hEE882266);
    wr(12'h018, 32'h00000004);
    chk("R7 masked irq", {31'b0, irq_o}, 32'h0);
    rd(12'h024, r); chk("R6 status when masked", r, 32'hF8000030);
    wr(12'h020, 32'h00000030);
    chk("R11 late enable no raise", {31'b0, irq_o}, 32'h0);
    wr(12'h024, 32'h00000020);
    rd(12'h024, r); chk("R9 bit5 clears both", r, 32'hF8000000);

    // R7 bit 4 alone enables
    wr(12'h020, 32'h00000010);
    rd(12'h020, r); chk("R8 ctrl bit4", r, 32'h00000010);
    wr(12'h01C, 32'hEE882266);
    wr(12'h018, 32'h00000008);
    chk("R7 bit4 raise", {31'b0, irq_o}, 32'h1);
    wr(12'h024, 32'h0F000000);
    chk("R9 no-op keeps irq", {31'b0, irq_o}, 32'h1);

    // R1 mid-run reset, arm then reset
    wr(12'h01C, 32'hEE882266);
    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(12'h010, r); chk("R1 base reset", r, 32'h0);
    wr(12'h018, 32'h00000001);
    rd(12'h024, r); chk("R1 arm cleared", r, 32'hF8000000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule